// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a 32.768 kHz crystal clock into a one-second tick for a real-time clock. It counts oscillator cycles and emits a single-cycle pulse at the end of each second. The external seconds counter advances on that pulse.

To correct for crystal error, a 7-bit trim field stretches or shrinks one second out of every twenty by an even number of cycles. The correction applies only to a second that starts while the BCD seconds input reads 00, 20 or 40. The first such boundary after a write to the trim field is passed over uncorrected. The field is written and read back through a simple byte port. An oscillator-stop flag forces it back to zero.

Top module: `sec_prescaler_trim`

## Requirements
- R1: A second that does not start at BCD seconds 8'h00, 8'h20 or 8'h40 lasts exactly NOMINAL_DIV oscillator cycles from one tick to the next, for example at seconds 8'h10, 8'h30 or 8'h50.
- R2: `tick` is high for one oscillator cycle at a time and is low on the cycle after every tick.
- R3: For a second that starts at seconds 8'h00, 8'h20 or 8'h40, with field bit 6 = 0 and bits 5:0 = m, the length is NOMINAL_DIV + (m - 1) * 2. For example, 7'h07 gives +12 and 7'h3F gives +124.
- R4: Under the same boundary condition with field bit 6 = 1, the length is NOMINAL_DIV - (64 - m) * 2. For example, 7'h7E gives -4 and 7'h42 gives -124.
- R5: When field bits 5:1 are all zero, no boundary second is changed, for any value of bits 6 and 0 (7'h01, 7'h41, 7'h40).
- R6: The first boundary second that starts after an accepted write keeps the nominal length. This includes a write accepted in the very cycle the boundary second starts. Later boundaries apply the new field.
- R7: A write with `wr_data[7]` = 1 is ignored: the field does not change and no boundary is skipped. `rd_data` bit 7 always reads 0, and bits 6:0 read the field.
- R8: While `osc_stop` is high, the field is cleared to zero and writes are refused. The next boundary second then has the nominal length.
- R9: During reset, `tick` is low and `rd_data` reads 8'h00. After reset is released, the first tick comes NOMINAL_DIV - 1 cycles after the first falling clock edge that follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_stop | input | 1 | Oscillator-stop / power-fail flag; clears the trim field |
| wr_en | input | 1 | Write strobe for the trim register |
| wr_data | input | 8 | Write data; bit 7 must be 0, bits 6:0 are the trim field |
| rd_data | output | 8 | Readback: 0 in bit 7, trim field in bits 6:0 |
| seconds_bcd | input | 8 | Current BCD seconds value from the seconds counter |
| tick | output | 1 | One-cycle pulse that ends each second |

## Verification
The hardest situation to reach is a write accepted in exactly the cycle that starts a boundary second. That cycle lasts one clock and only follows a tick. The bench times its stimulus from the falling edge on which a tick is seen. It sets the boundary seconds value on that edge and raises the write strobe on the next falling edge, so the write lands on the start cycle. It then measures the next two seconds to show that the skip was used up by that boundary. A table of seconds values, writes and expected second lengths walks every sign and magnitude corner of the trim field.

// File: rtl/sec_trim_pkg.sv
package sec_trim_pkg;

  localparam int TRIM_W   = 7;
  localparam int SEC_W    = 8;
  localparam int MAG_W    = TRIM_W - 1;
  localparam int MAG_SPAN = 2 ** MAG_W;
  // largest correction in either direction
  localparam int MAX_ADJ  = (MAG_SPAN - 2) * 2;

  // A boundary second starts at 00, 20 or 40 (BCD)
  function automatic logic is_boundary(input logic [SEC_W-1:0] s);
    return (s == 8'h00) || (s == 8'h20) || (s == 8'h40);
  endfunction

  // Null setting: magnitude bits above bit 0 all zero
  function automatic logic trim_is_null(input logic [TRIM_W-1:0] f);
    return (f[MAG_W-1:1] == '0);
  endfunction

  // Signed cycle correction for one boundary second
  function automatic int trim_delta(input logic [TRIM_W-1:0] f);
    int mag;
    mag = int'(f[MAG_W-1:0]);
    if (trim_is_null(f))
      return 0;
    else if (!f[TRIM_W-1])
      return (mag - 1) * 2;
    else
      return -((MAG_SPAN - mag) * 2);
  endfunction

endpackage

// File: rtl/trim_reg_bank.sv
module trim_reg_bank
  import sec_trim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_stop,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [TRIM_W-1:0] trim,
  output logic              wr_accept
);

  // the guard bit must be written as zero; a stop flag refuses writes
  assign wr_accept = wr_en && !wr_data[7] && !osc_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trim <= '0;
    else if (osc_stop)
      trim <= '0;
    else if (wr_accept)
      trim <= wr_data[TRIM_W-1:0];
  end

  assign rd_data = {1'b0, trim};

endmodule

// File: rtl/trim_gate.sv
module trim_gate
  import sec_trim_pkg::*;
#(
  parameter int NOMINAL_DIV = 32768,
  parameter int CNT_W       = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_stop,
  input  logic              wr_accept,
  input  logic              sec_start,
  input  logic [SEC_W-1:0]  seconds_bcd,
  input  logic [TRIM_W-1:0] trim,
  output logic              boundary_hit,
  output logic              skip_hit,
  output logic              apply_hit,
  output logic [CNT_W-1:0]  len_sel
);

  logic pending;

  assign boundary_hit = sec_start && is_boundary(seconds_bcd);
  // a write now or since the last boundary blocks this boundary
  assign skip_hit     = boundary_hit && (pending || wr_accept);
  assign apply_hit    = boundary_hit && !skip_hit;

  always_comb begin
    if (apply_hit)
      len_sel = CNT_W'(NOMINAL_DIV + trim_delta(trim));
    else
      len_sel = CNT_W'(NOMINAL_DIV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending <= 1'b0;
    else if (osc_stop || boundary_hit)
      pending <= 1'b0;
    else if (wr_accept)
      pending <= 1'b1;
  end

endmodule

// File: rtl/second_divider.sv
module second_divider #(
  parameter int NOMINAL_DIV = 32768,
  parameter int CNT_W       = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] len_sel,
  output logic             sec_start,
  output logic             tick,
  output logic [CNT_W-1:0] term_len
);

  logic [CNT_W-1:0] cnt;

  assign sec_start = (cnt == '0);
  assign tick      = (cnt == term_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (tick)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  // length of the running second is fixed in its first cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      term_len <= CNT_W'(NOMINAL_DIV);
    else if (sec_start)
      term_len <= len_sel;
  end

endmodule

// File: rtl/sec_prescaler_trim.sv
module sec_prescaler_trim
  import sec_trim_pkg::*;
#(
  parameter int NOMINAL_DIV = 32768
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_stop,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [7:0] seconds_bcd,
  output logic       tick
);

  localparam int CNT_W = $clog2(NOMINAL_DIV + MAX_ADJ + 1);

  logic [TRIM_W-1:0] trim;
  logic              wr_accept;
  logic              sec_start;
  logic              boundary_hit;
  logic              skip_hit;
  logic              apply_hit;
  logic [CNT_W-1:0]  len_sel;
  logic [CNT_W-1:0]  term_len;

  trim_reg_bank u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_stop  (osc_stop),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .trim      (trim),
    .wr_accept (wr_accept)
  );

  trim_gate #(.NOMINAL_DIV(NOMINAL_DIV), .CNT_W(CNT_W)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_stop     (osc_stop),
    .wr_accept    (wr_accept),
    .sec_start    (sec_start),
    .seconds_bcd  (seconds_bcd),
    .trim         (trim),
    .boundary_hit (boundary_hit),
    .skip_hit     (skip_hit),
    .apply_hit    (apply_hit),
    .len_sel      (len_sel)
  );

  second_divider #(.NOMINAL_DIV(NOMINAL_DIV), .CNT_W(CNT_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_sel   (len_sel),
    .sec_start (sec_start),
    .tick      (tick),
    .term_len  (term_len)
  );

endmodule

// File: rtl/sec_prescaler_trim_chk.sv
module sec_prescaler_trim_chk #(
  parameter int NOMINAL_DIV = 32768,
  parameter int CNT_W       = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             osc_stop,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic             tick,
  input logic             sec_start,
  input logic             boundary_hit,
  input logic             skip_hit,
  input logic             wr_accept,
  input logic [CNT_W-1:0] term_len
);

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_start_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sec_start);

  assert_plain_second_nominal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_start && !boundary_hit) |=> (term_len == CNT_W'(NOMINAL_DIV)));

  assert_skip_nominal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    skip_hit |=> (term_len == CNT_W'(NOMINAL_DIV)));

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> (rd_data == 8'h00));

  assert_guard_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && !osc_stop) |=> $stable(rd_data));

  assert_write_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (rd_data == {1'b0, $past(wr_data[6:0])}));

  always_comb begin
    assert_bit7_zero_R7: assert (rd_data[7] == 1'b0);
  end

endmodule

bind sec_prescaler_trim sec_prescaler_trim_chk #(
  .NOMINAL_DIV(NOMINAL_DIV),
  .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sec_prescaler_trim_bench.sv
`timescale 1ns/1ps
module sec_prescaler_trim_bench;

  localparam int NOM = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc_stop;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [7:0] seconds_bcd;
  logic       tick;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sec_prescaler_trim #(.NOMINAL_DIV(NOM)) u_sec_prescaler_trim (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_stop    (osc_stop),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .seconds_bcd (seconds_bcd),
    .tick        (tick)
  );

  // {seconds, write, write data, expected length of this second}
  localparam int NV = 30;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {8'h00, 1'b0, 8'h00, 16'd256},  // R5 reset value 0
    {8'h01, 1'b1, 8'h07, 16'd256},  // R1 write during plain second
    {8'h20, 1'b0, 8'h00, 16'd256},  // R6 first boundary skipped
    {8'h21, 1'b0, 8'h00, 16'd256},
    {8'h40, 1'b0, 8'h00, 16'd268},  // R3 (7-1)*2
    {8'h41, 1'b1, 8'h7E, 16'd256},
    {8'h00, 1'b0, 8'h00, 16'd256},  // R6
    {8'h20, 1'b0, 8'h00, 16'd252},  // R4 -4
    {8'h10, 1'b0, 8'h00, 16'd256},  // R1
    {8'h30, 1'b1, 8'h81, 16'd256},  // R7 guarded write
    {8'h40, 1'b0, 8'h00, 16'd252},  // R7 no skip, field kept
    {8'h02, 1'b1, 8'h3F, 16'd256},
    {8'h00, 1'b0, 8'h00, 16'd256},  // R6
    {8'h20, 1'b0, 8'h00, 16'd380},  // R3 +124
    {8'h03, 1'b1, 8'h42, 16'd256},
    {8'h40, 1'b0, 8'h00, 16'd256},  // R6
    {8'h00, 1'b0, 8'h00, 16'd132},  // R4 -124
    {8'h04, 1'b1, 8'h41, 16'd256},
    {8'h20, 1'b0, 8'h00, 16'd256},
    {8'h40, 1'b0, 8'h00, 16'd256},  // R5 7'h41
    {8'h05, 1'b1, 8'h01, 16'd256},
    {8'h00, 1'b0, 8'h00, 16'd256},
    {8'h20, 1'b0, 8'h00, 16'd256},  // R5 7'h01
    {8'h06, 1'b1, 8'h40, 16'd256},
    {8'h40, 1'b0, 8'h00, 16'd256},
    {8'h00, 1'b0, 8'h00, 16'd256},  // R5 7'h40
    {8'h07, 1'b1, 8'h02, 16'd256},
    {8'h20, 1'b0, 8'h00, 16'd256},
    {8'h40, 1'b0, 8'h00, 16'd258},  // R3 +2
    {8'h50, 1'b0, 8'h00, 16'd256}   // R1
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called on the falling edge where a tick is seen; measures next second
  task automatic run_second(input logic [7:0] s, input logic we,
                            input logic [7:0] wd, input int wr_at,
                            output int n);
    seconds_bcd = s;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      wr_en   = we && (n == wr_at);
      wr_data = wd;
    end while (!tick && n < 2000);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!tick && g < 2000);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; osc_stop = 1'b0; wr_en = 1'b0;
    wr_data = 8'h00; seconds_bcd = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 reset tick", int'(tick), 0);
    check("R9 reset readback", int'(rd_data), 0);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 2000);
    check("R9 first second length", n, NOM - 1);

    for (int i = 0; i < NV; i++) begin
      run_second(VEC[i][32:25], VEC[i][24], VEC[i][23:16], 3, n);
      check($sformatf("R1 R3 R4 R5 R6 R7 vector %0d length", i),
            n, int'(VEC[i][15:0]));
    end

    check("R7 readback after table", int'(rd_data), 8'h02);
    run_second(8'h11, 1'b1, 8'hFF, 3, n);
    check("R1 plain second with guarded write", n, NOM);
    check("R7 guarded write leaves field", int'(rd_data), 8'h02);

    // write lands on the start cycle of a boundary second
    run_second(8'h00, 1'b1, 8'h07, 1, n);
    check("R6 coincident write boundary nominal", n, NOM);
    check("R7 readback of 7'h07", int'(rd_data), 8'h07);
    run_second(8'h01, 1'b0, 8'h00, 3, n);
    check("R1 second after coincident write", n, NOM);
    run_second(8'h20, 1'b0, 8'h00, 3, n);
    check("R6 R3 next boundary applies", n, NOM + 12);

    // oscillator stop clears field
    seconds_bcd = 8'h21;
    @(negedge clk);
    osc_stop = 1'b1;
    @(negedge clk);
    osc_stop = 1'b0;
    check("R8 field cleared", int'(rd_data), 0);
    wait_tick();
    run_second(8'h40, 1'b0, 8'h00, 3, n);
    check("R8 boundary after stop nominal", n, NOM);

    @(negedge clk);
    check("R2 tick low after pulse", int'(tick), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule